// File: doc/BRIEF.md
# Heterodyne Beat Period Meter

This block turns the signal of a capacitive-sensor oscillator into one number per audio frame. A single flip-flop is clocked by the sensor oscillator and samples a reference clock. Its output toggles near the difference between the two frequencies. That slow beat is carried into the timebase clock domain, and a free-running interval counter measures the time between selected beat edges in timebase cycles.

Every measured interval that completes within a frame is summed. When the frame tick arrives, the block presents the sum and the number of intervals, and the consumer divides one by the other to get a mean period. The averaging depth sets an upper limit on how many intervals enter one frame, which trades precision against how old the oldest contribution may be. In both-edge mode the block measures half periods and doubles the reported sum, so the quotient still gives a full period with twice as many contributions.

The reference must come from a source that is independent of the timebase clock. Otherwise the beat phase locks to the counter and the average stops improving.

Top module: `beat_period_meter`

## Requirements
- R1: The mixing flop samples `ref_in` on the rising edge of `osc_in`, and its output passes through two timebase flops before edge detection. A reference with a period of P timebase cycles, sampled by an oscillator locked to `clk`, yields intervals of exactly P.
- R2: `edge_mode` selects the edges that delimit an interval: 2'b00 rising, 2'b01 falling, 2'b10 or 2'b11 both. An interval is the number of `clk` cycles between two consecutive selected edges.
- R3: In both-edge mode each half period counts as one contribution. `res_cnt` counts half periods and `res_sum` is twice the sum of the half periods.
- R4: `res_valid` is high for exactly the one cycle after a cycle with `frame_tick` high. `res_sum`, `res_cnt`, `res_stale` and `res_timeout` change only in that cycle.
- R5: An interval that completes in the same cycle as `frame_tick` belongs to the frame closed by that tick. A frame of k·P cycles over a steady beat of period P therefore always reports exactly k periods, whatever the phase of the beat.
- R6: At most 2^`avg_depth` intervals are accepted per frame, and later ones in the same frame are dropped. A depth above `MAX_DEPTH` acts as `MAX_DEPTH`.
- R7: If a frame accepted no interval, `res_sum` and `res_cnt` keep their previous values and `res_stale` is 1. Otherwise `res_stale` is 0.
- R8: The interval counter saturates at 2^`PER_W`-1. `res_timeout` is 1 for any frame in which the armed counter was saturated, and an interval that ends after saturation produces no contribution.
- R9: After reset, the first selected edge only arms the counter and contributes nothing.
- R10: While `rst_n` is low and until the first frame tick, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Measurement timebase clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| osc_in | input | 1 | Sensor oscillator; clocks the mixing flop |
| ref_in | input | 1 | Reference clock; data input of the mixing flop |
| frame_tick | input | 1 | One-cycle pulse that closes a frame |
| edge_mode | input | 2 | 00 rising, 01 falling, 1x both edges |
| avg_depth | input | DEP_W | log2 of the per-frame interval limit |
| res_valid | output | 1 | Result strobe, the cycle after `frame_tick` |
| res_sum | output | PER_W+MAX_DEPTH+1 | Sum of accepted intervals (doubled in both-edge mode) |
| res_cnt | output | MAX_DEPTH+1 | Number of accepted intervals |
| res_stale | output | 1 | No interval in the frame; previous result repeated |
| res_timeout | output | 1 | Interval counter saturated during the frame |

## Verification
A beat edge and the frame tick can fall in the same cycle, and the block must then put that interval into the frame being closed. The bench runs a steady beat of period 20 with frames of 40 cycles and, before each checked frame, inserts one frame that is a single cycle longer. Over twenty repetitions this walks the tick through every phase of the beat, so one of them must coincide with an edge. Each checked frame must report exactly 2 periods with a sum of 40. Losing or double-counting the coincident edge would give 1 or 3.

// File: rtl/bpm_pkg.sv
package bpm_pkg;

  typedef enum logic [1:0] {
    EDGE_RISE = 2'b00,
    EDGE_FALL = 2'b01,
    EDGE_BOTH = 2'b10,
    EDGE_ALSO = 2'b11
  } edge_sel_e;

endpackage

// File: rtl/bpm_mixer_sync.sv
module bpm_mixer_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arst_n,
  input  logic osc_in,
  input  logic ref_in,
  output logic beat_sync
);

  logic                   mix_q;
  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_d;

  // heterodyne mixer: oscillator clocks, reference is sampled
  always_ff @(posedge osc_in or negedge arst_n) begin
    if (!arst_n) mix_q <= 1'b0;
    else         mix_q <= ref_in;
  end

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_comb sync_d[s] = mix_q;
      end else begin : g_next
        always_comb sync_d[s] = sync_q[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign beat_sync = sync_q[SYNC_STAGES-1];

  // R1: the synchronized beat follows the first stage one cycle later
  assert_sync_chain_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_q[SYNC_STAGES-2] != beat_sync) |=> (beat_sync == $past(sync_q[SYNC_STAGES-2])));

endmodule

// File: rtl/bpm_interval_timer.sv
module bpm_interval_timer
  import bpm_pkg::*;
#(
  parameter int PER_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat,
  input  logic [1:0]       edge_mode,
  output logic             smp_vld,
  output logic [PER_W-1:0] smp_val,
  output logic             sat
);

  localparam logic [PER_W-1:0] CNT_MAX = {PER_W{1'b1}};

  logic             prev_q;
  logic             armed_q, armed_d;
  logic [PER_W-1:0] cnt_q, cnt_d;
  logic             rise, fall, sel_edge;
  logic             at_max;

  always_comb begin
    rise   = beat & ~prev_q;
    fall   = ~beat & prev_q;
    at_max = (cnt_q == CNT_MAX);
    unique case (edge_sel_e'(edge_mode))
      EDGE_RISE: sel_edge = rise;
      EDGE_FALL: sel_edge = fall;
      default:   sel_edge = rise | fall;
    endcase
  end

  // next state
  always_comb begin
    armed_d = armed_q;
    cnt_d   = cnt_q;
    if (sel_edge) begin
      armed_d = 1'b1;
      cnt_d   = PER_W'(1);
    end else if (!at_max) begin
      cnt_d   = cnt_q + PER_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      prev_q  <= beat;
      armed_q <= armed_d;
      cnt_q   <= cnt_d;
    end
  end

  assign smp_vld = sel_edge & armed_q & ~at_max;
  assign smp_val = cnt_q;
  assign sat     = armed_q & at_max;

  // R2: a delivered interval is never empty
  assert_interval_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld |-> (smp_val != '0));

  // R8: between edges the counter never moves backwards
  assert_counter_monotonic_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_edge |=> (cnt_q >= $past(cnt_q)));

endmodule

// File: rtl/bpm_frame_accum.sv
module bpm_frame_accum #(
  parameter int PER_W     = 17,
  parameter int MAX_DEPTH = 6,
  parameter int DEP_W     = 3,
  localparam int ACC_W    = PER_W + MAX_DEPTH,
  localparam int SUM_W    = ACC_W + 1,
  localparam int CNT_W    = MAX_DEPTH + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_vld,
  input  logic [PER_W-1:0] smp_val,
  input  logic             sat,
  input  logic             both_mode,
  input  logic [DEP_W-1:0] avg_depth,
  input  logic             frame_tick,
  output logic             res_valid,
  output logic [SUM_W-1:0] res_sum,
  output logic [CNT_W-1:0] res_cnt,
  output logic             res_stale,
  output logic             res_timeout
);

  logic [ACC_W-1:0] acc_sum_q, acc_sum_d, acc_sum_nx;
  logic [CNT_W-1:0] acc_cnt_q, acc_cnt_d, acc_cnt_nx;
  logic             to_q, to_d, to_nx;
  logic [DEP_W-1:0] depth_eff;
  logic [CNT_W-1:0] cap;
  logic             take;

  logic             valid_d, stale_d, tout_d;
  logic [SUM_W-1:0] sum_d;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    depth_eff  = (avg_depth > DEP_W'(MAX_DEPTH)) ? DEP_W'(MAX_DEPTH) : avg_depth;
    cap        = CNT_W'(1) << depth_eff;
    take       = smp_vld && (acc_cnt_q < cap);
    acc_sum_nx = acc_sum_q + (take ? {{MAX_DEPTH{1'b0}}, smp_val} : '0);
    acc_cnt_nx = acc_cnt_q + CNT_W'(take);
    to_nx      = to_q | sat;
  end

  // next state
  always_comb begin
    acc_sum_d = acc_sum_nx;
    acc_cnt_d = acc_cnt_nx;
    to_d      = to_nx;
    valid_d   = 1'b0;
    sum_d     = res_sum;
    cnt_d     = res_cnt;
    stale_d   = res_stale;
    tout_d    = res_timeout;
    if (frame_tick) begin
      acc_sum_d = '0;
      acc_cnt_d = '0;
      to_d      = 1'b0;
      valid_d   = 1'b1;
      tout_d    = to_nx;
      if (acc_cnt_nx != '0) begin
        sum_d   = both_mode ? {acc_sum_nx, 1'b0} : {1'b0, acc_sum_nx};
        cnt_d   = acc_cnt_nx;
        stale_d = 1'b0;
      end else begin
        stale_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_sum_q   <= '0;
      acc_cnt_q   <= '0;
      to_q        <= 1'b0;
      res_valid   <= 1'b0;
      res_sum     <= '0;
      res_cnt     <= '0;
      res_stale   <= 1'b0;
      res_timeout <= 1'b0;
    end else begin
      acc_sum_q   <= acc_sum_d;
      acc_cnt_q   <= acc_cnt_d;
      to_q        <= to_d;
      res_valid   <= valid_d;
      res_sum     <= sum_d;
      res_cnt     <= cnt_d;
      res_stale   <= stale_d;
      res_timeout <= tout_d;
    end
  end

  assert_valid_after_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_tick |=> res_valid);

  assert_no_valid_without_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_tick |=> (!res_valid && $stable(res_sum) && $stable(res_cnt)));

  assert_stale_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_stale) |-> ($stable(res_sum) && $stable(res_cnt)));

  assert_fresh_nonempty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_stale) |-> (res_cnt != '0));

  assert_count_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_cnt <= CNT_W'(1 << MAX_DEPTH)));

endmodule

// File: rtl/beat_period_meter.sv
module beat_period_meter #(
  parameter int PER_W       = 17,
  parameter int MAX_DEPTH   = 6,
  parameter int DEP_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       osc_in,
  input  logic                       ref_in,
  input  logic                       frame_tick,
  input  logic [1:0]                 edge_mode,
  input  logic [DEP_W-1:0]           avg_depth,
  output logic                       res_valid,
  output logic [PER_W+MAX_DEPTH:0]   res_sum,
  output logic [MAX_DEPTH:0]         res_cnt,
  output logic                       res_stale,
  output logic                       res_timeout
);

  logic [1:0]       rst_sync_q;
  logic             rst_n_s;
  logic             beat;
  logic             smp_vld;
  logic [PER_W-1:0] smp_val;
  logic             sat;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  bpm_mixer_sync #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_mix (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .arst_n   (rst_n),
    .osc_in   (osc_in),
    .ref_in   (ref_in),
    .beat_sync(beat)
  );

  bpm_interval_timer #(
    .PER_W(PER_W)
  ) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .beat     (beat),
    .edge_mode(edge_mode),
    .smp_vld  (smp_vld),
    .smp_val  (smp_val),
    .sat      (sat)
  );

  bpm_frame_accum #(
    .PER_W    (PER_W),
    .MAX_DEPTH(MAX_DEPTH),
    .DEP_W    (DEP_W)
  ) u_acc (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .smp_vld    (smp_vld),
    .smp_val    (smp_val),
    .sat        (sat),
    .both_mode  (edge_mode[1]),
    .avg_depth  (avg_depth),
    .frame_tick (frame_tick),
    .res_valid  (res_valid),
    .res_sum    (res_sum),
    .res_cnt    (res_cnt),
    .res_stale  (res_stale),
    .res_timeout(res_timeout)
  );

endmodule

// File: tb/beat_period_meter_tb.sv
module beat_period_meter_tb;

  localparam int CLK_PERIOD = 10;
  localparam int PER_W      = 12;
  localparam int MAX_DEPTH  = 6;
  localparam int DEP_W      = 3;
  localparam int WD_CYCLES  = 190000;

  localparam int NV = 10;
  localparam int V_MODE [NV] = '{0, 0, 1, 2, 2, 0, 2, 0, 0, 2};
  localparam int V_DEP  [NV] = '{6, 6, 6, 6, 6, 2, 1, 7, 0, 3};
  localparam int V_H    [NV] = '{10, 7, 30, 10, 6, 5, 9, 5, 12, 50};
  localparam int V_L    [NV] = '{10, 18, 11, 10, 17, 5, 4, 5, 12, 50};
  localparam int V_K    [NV] = '{3, 4, 2, 3, 4, 6, 3, 70, 2, 5};

  logic clk, osc_in, rst_n, ref_in, frame_tick;
  logic [1:0] edge_mode;
  logic [DEP_W-1:0] avg_depth;
  logic res_valid, res_stale, res_timeout;
  logic [PER_W+MAX_DEPTH:0] res_sum;
  logic [MAX_DEPTH:0] res_cnt;

  int total, bad;
  int ref_h, ref_l;
  bit ref_run;

  beat_period_meter #(
    .PER_W(PER_W), .MAX_DEPTH(MAX_DEPTH), .DEP_W(DEP_W), .SYNC_STAGES(2)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .osc_in(osc_in), .ref_in(ref_in),
    .frame_tick(frame_tick), .edge_mode(edge_mode), .avg_depth(avg_depth),
    .res_valid(res_valid), .res_sum(res_sum), .res_cnt(res_cnt),
    .res_stale(res_stale), .res_timeout(res_timeout)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  // oscillator locked to the timebase, rising 2 time units after clk
  initial begin
    osc_in = 1'b0;
    #2;
    forever #(CLK_PERIOD/2) osc_in = ~osc_in;
  end

  // reference generator, changes on falling clk edges
  initial begin
    ref_in = 1'b0;
    forever begin
      if (ref_run) begin
        ref_in = 1'b1;
        repeat (ref_h) @(negedge clk);
        ref_in = 1'b0;
        repeat (ref_l) @(negedge clk);
      end else begin
        @(negedge clk);
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_res(input string req, input int cnt, input int sum,
                         input int stale, input int tout);
    chk(req, "res_valid", int'(res_valid), 1);
    chk(req, "res_cnt", int'(res_cnt), cnt);
    chk(req, "res_sum", int'(res_sum), sum);
    chk(req, "res_stale", int'(res_stale), stale);
    chk(req, "res_timeout", int'(res_timeout), tout);
  endtask

  // frame of f cycles; returns at the falling edge where the result is visible
  task automatic run_frame(input int f);
    repeat (f - 1) @(negedge clk);
    frame_tick = 1'b1;
    @(negedge clk);
    frame_tick = 1'b0;
  endtask

  task automatic configure(input int mode, input int dep, input int h, input int l);
    edge_mode = 2'(mode);
    avg_depth = DEP_W'(dep);
    ref_h     = h;
    ref_l     = l;
    ref_run   = 1'b1;
    repeat (256) @(negedge clk);
  endtask

  task automatic summary;
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=0", WD_CYCLES);
    summary();
    $finish;
  end

  initial begin
    int s1, c1;
    total = 0; bad = 0;
    rst_n = 1'b0; frame_tick = 1'b0; ref_run = 1'b0;
    ref_h = 10; ref_l = 10;
    edge_mode = 2'b00; avg_depth = DEP_W'(6);

    // R10: outputs quiet during reset
    repeat (5) @(negedge clk);
    chk("R10", "res_valid in reset", int'(res_valid), 0);
    chk("R10", "res_sum in reset", int'(res_sum), 0);
    chk("R10", "res_cnt in reset", int'(res_cnt), 0);
    chk("R10", "flags in reset", int'({res_stale, res_timeout}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10", "res_valid before tick", int'(res_valid), 0);

    // R9: first edge only arms; 3 rising edges in 60 cycles give 2 periods
    ref_run = 1'b1;
    run_frame(60);
    chk_res("R9", 2, 40, 0, 0);
    // R4: strobe lasts a single cycle
    @(negedge clk);
    chk("R4", "res_valid one cycle", int'(res_valid), 0);
    chk("R4", "res_sum held", int'(res_sum), 40);

    // R1 R2 R3 R6: vector table, expected sum is count times period
    for (int i = 0; i < NV; i++) begin
      int per, e, dcl, cap, cnt;
      string tag;
      per = V_H[i] + V_L[i];
      e   = (V_MODE[i] >= 2) ? 2 : 1;
      dcl = (V_DEP[i] > MAX_DEPTH) ? MAX_DEPTH : V_DEP[i];
      cap = 1 << dcl;
      cnt = (V_K[i] * e < cap) ? V_K[i] * e : cap;
      if (cap < V_K[i] * e)  tag = "R6";
      else if (e == 2)       tag = "R3";
      else                   tag = "R1 R2";
      configure(V_MODE[i], V_DEP[i], V_H[i], V_L[i]);
      run_frame(V_K[i] * per);
      run_frame(V_K[i] * per);
      chk_res(tag, cnt, cnt * per, 0, 0);
    end

    // R5: walk the frame tick across every beat phase
    configure(0, 6, 10, 10);
    run_frame(40);
    for (int s = 0; s < 20; s++) begin
      run_frame(41);
      run_frame(40);
      chk_res("R5", 2, 40, 0, 0);
    end

    // R7 R8: stopped beat, stale frames and saturation
    run_frame(40);
    chk_res("R7", 2, 40, 0, 0);
    ref_run = 1'b0;
    run_frame(2500);
    s1 = int'(res_sum);
    c1 = int'(res_cnt);
    run_frame(2500);
    chk_res("R7", c1, s1, 1, 1);
    run_frame(2500);
    chk_res("R8", c1, s1, 1, 1);
    // restart: the edge ending the saturated interval is discarded
    ref_run = 1'b1;
    run_frame(60);
    chk_res("R8", 2, 40, 0, 1);
    run_frame(60);
    chk_res("R8", 3, 60, 0, 0);

    summary();
    $finish;
  end

endmodule